// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Automatic Retry

This block sends single characters on a half-duplex smart-card I/O line in the character-oriented protocol (T=0). Each character is a low start bit, eight data bits least significant bit first, and an even parity bit. After the parity bit the block lets go of the line for a guard bit. Halfway through that guard bit it samples the line. A low level there means the card has rejected the character (NACK). The block then waits two bit times and sends the same byte again. It does this up to a programmed number of repeats and raises a sticky flag once the allowance has been used.

Timing comes from `sampleTick`, a one-cycle strobe that runs at twice the bit rate. One bit time (etu) is therefore two strobes, and every second strobe falls in the middle of a bit. Bytes enter through a valid/ready handshake. The line is open-drain: `lineLow` pulls it down, and `lineIn` is the level read back from the wire. Clock division and register access live outside this block.

Top module: `sc_retry_tx`

## Requirements
- R1: While sending, `lineLow`=1 pulls the line low and `lineLow`=0 releases it. A frame is the start bit (low), then data bits 0 to 7, then a parity bit equal to the XOR of the eight data bits, so the count of ones is even. Each bit lasts two `sampleTick` strobes. The line is released at all other times.
- R2: `txReady` is high only when the block is idle. A byte is taken on a clock where `txValid` and `txReady` are both high. Its start bit begins on the first `sampleTick` after that clock.
- R3: The line is sampled for a NACK only on the second `sampleTick` of the guard bit, the middle of the guard bit. A low level at any other time has no effect.
- R4: When `maxIter` is 0, a NACK causes no retransmission, and `txReady` returns at the end of the guard bit.
- R5: After a NACK that qualifies for a repeat, the start bit of the repeat begins four `sampleTick` strobes (two etu) after the end of the guard bit, and it carries the same byte.
- R6: One byte is repeated at most `maxIter` times (3 bits), so it is sent at most eight times in all.
- R7: `iterFlag` is set when the number of repeats for a byte reaches `maxIter` (`maxIter` > 0). It then stays set across later bytes.
- R8: A one-cycle pulse on `clrIter` clears `iterFlag`. If the flag is being set in the same cycle, the set wins.
- R9: When a repeat is accepted (no NACK), repetition stops and the repeat count returns to zero. The next byte gets the full `maxIter` allowance again.
- R10: When the last permitted attempt is also NACKed, the block gives up on that byte and becomes ready for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Strobe at twice the etu rate |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Block idle and able to take a byte |
| maxIter | input | 3 | Maximum number of repeats per byte |
| clrIter | input | 1 | Clears the iteration flag |
| lineIn | input | 1 | Level read back from the I/O line |
| lineLow | output | 1 | 1 pulls the I/O line low |
| iterFlag | output | 1 | Sticky flag: repeat limit reached |

## Verification
An error in the bit position or phase counter shifts or truncates the waveform on `lineLow`. That shows within one half-etu of the fault, so the output is compared against an independent model on every clock. A wrong repeat count or a missed NACK is invisible while the line is idle. It only shows as a start bit that is missing or extra, about thirteen etu later, or as `iterFlag` rising at the wrong attempt. For that reason the bench also counts start bits per byte across scenarios with full NACK, partial NACK, zero allowance and a NACK pulse placed away from mid-guard.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SEND,
    ST_GUARD,
    ST_BACKOFF
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take the offered byte
    logic reload;   // build a fresh frame from the held byte
    logic shift;    // advance to the next frame bit
    logic drive;    // frame bit is on the line
  } txStrobe_t;

endpackage

// File: rtl/sc_tx_datapath.sv
module sc_tx_datapath
  import sc_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  txStrobe_t         str,
  output logic              lineLow
);

  localparam int FRAME_W = DATA_W + 2;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic               parityBit;

  generate
    if (ODD_PARITY) begin : g_odd
      assign parityBit = ~(^holdReg);
    end else begin : g_even
      assign parityBit = ^holdReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (str.capture) holdReg <= txData;
      if (str.reload) begin
        shiftReg <= {parityBit, holdReg, 1'b0};
      end else if (str.shift) begin
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      end
    end
  end

  assign lineLow = str.drive & ~shiftReg[0];

  // R1: every frame opens with a low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(str.drive) |-> lineLow);

endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
  import sc_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ITER_W      = 3,
  parameter int BACKOFF_ETU = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              txValid,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              clrIter,
  input  logic              lineIn,
  output logic              txReady,
  output logic              iterFlag,
  output txStrobe_t         str
);

  localparam int LAST_BIT   = DATA_W + 1;
  localparam int BIT_W      = $clog2(LAST_BIT + 1);
  localparam int WAIT_TICKS = 2 * BACKOFF_ETU;
  localparam int WAIT_W     = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;

  txState_t          state;
  logic [BIT_W-1:0]  bitIdx;
  logic              phase;
  logic              nackSeen;
  logic [ITER_W-1:0] repCount;
  logic [WAIT_W-1:0] waitCnt;

  logic guardEnd, retryOk, setFlag, waitDone;

  assign guardEnd = (state == ST_GUARD) && sampleTick && phase;
  assign retryOk  = nackSeen && (maxIter != '0) && (repCount < maxIter);
  assign setFlag  = guardEnd && retryOk && ((repCount + 1'b1) == maxIter);
  assign waitDone = (waitCnt == WAIT_W'(WAIT_TICKS - 1));

  always_comb begin
    str.capture = (state == ST_IDLE) && txValid;
    str.reload  = sampleTick && ((state == ST_ARM) ||
                                 ((state == ST_BACKOFF) && waitDone));
    str.shift   = (state == ST_SEND) && sampleTick && phase &&
                  (bitIdx != BIT_W'(LAST_BIT));
    str.drive   = (state == ST_SEND);
  end

  assign txReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      phase    <= 1'b0;
      nackSeen <= 1'b0;
      repCount <= '0;
      waitCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (txValid) state <= ST_ARM;
        ST_ARM: if (sampleTick) begin
          state  <= ST_SEND;
          bitIdx <= '0;
          phase  <= 1'b0;
        end
        ST_SEND: if (sampleTick) begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bitIdx == BIT_W'(LAST_BIT)) state <= ST_GUARD;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_GUARD: if (sampleTick) begin
          if (!phase) begin
            phase    <= 1'b1;
            nackSeen <= ~lineIn;
          end else begin
            phase <= 1'b0;
            if (retryOk) begin
              repCount <= repCount + 1'b1;
              waitCnt  <= '0;
              state    <= ST_BACKOFF;
            end else begin
              repCount <= '0;
              state    <= ST_IDLE;
            end
          end
        end
        ST_BACKOFF: if (sampleTick) begin
          if (waitDone) begin
            state  <= ST_SEND;
            bitIdx <= '0;
            phase  <= 1'b0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        iterFlag <= 1'b0;
    else if (setFlag) iterFlag <= 1'b1;
    else if (clrIter) iterFlag <= 1'b0;
  end

  // R2: never ready while a frame bit is on the line
  a_r2_ready_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !str.drive);

  // R7: flag stays up until a clear command
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (iterFlag && !clrIter) |=> iterFlag);

  // R7: flag rises exactly when the repeat count meets the limit
  a_r7_flag_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(iterFlag) |-> ((repCount == maxIter) && (maxIter != '0)));

  // R9: an idle block holds no leftover repeat count
  a_r9_idle_count_clear: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (repCount == '0));

endmodule

// File: rtl/sc_retry_tx.sv
module sc_retry_tx
  import sc_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ITER_W      = 3,
  parameter int BACKOFF_ETU = 2,
  parameter bit ODD_PARITY  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              clrIter,
  input  logic              lineIn,
  output logic              lineLow,
  output logic              iterFlag
);

  txStrobe_t str;

  sc_tx_ctrl #(
    .DATA_W     (DATA_W),
    .ITER_W     (ITER_W),
    .BACKOFF_ETU(BACKOFF_ETU)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .txValid   (txValid),
    .maxIter   (maxIter),
    .clrIter   (clrIter),
    .lineIn    (lineIn),
    .txReady   (txReady),
    .iterFlag  (iterFlag),
    .str       (str)
  );

  sc_tx_datapath #(
    .DATA_W    (DATA_W),
    .ODD_PARITY(ODD_PARITY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .txData (txData),
    .str    (str),
    .lineLow(lineLow)
  );

endmodule

// File: tb/sc_retry_tx_tb.sv
module sc_retry_tx_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sampleTick;
  logic [7:0] txData;
  logic       txValid;
  logic       txReady;
  logic [2:0] maxIter;
  logic       clrIter;
  logic       lineIn;
  logic       lineLow;
  logic       iterFlag;
  logic       cardPull;

  always #10 clk = ~clk;  // 50 MHz

  assign lineIn = ~(lineLow | cardPull);

  sc_retry_tx u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .txData(txData),
    .txValid(txValid), .txReady(txReady), .maxIter(maxIter),
    .clrIter(clrIter), .lineIn(lineIn), .lineLow(lineLow), .iterFlag(iterFlag)
  );

  int total = 0;
  int bad = 0;
  int divCnt = 0;
  int nackFirst = 0;   // number of leading attempts the card rejects
  int pullStyle = 0;   // 0: pull across mid-guard, 1: short pulse before mid-guard
  bit compareOn = 0;

  // reference model state
  int       mMode = 0;   // 0 idle, 1 waiting for tick, 2 busy with a byte
  int       mK = 0;      // half-etu count since the current start bit began
  int       mReps = 0;
  bit       mNack = 0;
  bit       mFlag = 0;
  bit [7:0] mByte = 8'h00;

  int  starts = 0;
  int  relRun = 100;
  bit  prevLow = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expLow();
    bit [9:0] fr;
    if (mMode != 2 || mK >= 20) return 1'b0;
    fr = {^mByte, mByte, 1'b0};
    return ~fr[mK / 2];
  endfunction

  // model advances on the clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mK = 0; mReps = 0; mNack = 0; mFlag = 0;
    end else begin
      if (clrIter) mFlag = 0;
      case (mMode)
        0: if (txValid) begin mMode = 1; mByte = txData; end
        1: if (sampleTick) begin mMode = 2; mK = 0; end
        default: if (sampleTick) begin
          mK++;
          if (mK == 21) mNack = cardPull;
          else if (mK == 22) begin
            if (mNack && maxIter != 0 && mReps < int'(maxIter)) begin
              mReps++;
              if (mReps == int'(maxIter)) mFlag = 1;
            end else begin
              mMode = 0; mReps = 0;
            end
          end else if (mK == 26) mK = 0;
        end
      endcase
    end
  end

  // tick generator and card responder, away from the active edge
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    sampleTick = (divCnt == 3);
    cardPull = 1'b0;
    if (mMode == 2 && mReps < nackFirst) begin
      if (pullStyle == 0 && (mK == 20 || mK == 21)) cardPull = 1'b1;
      if (pullStyle == 1 && mK == 20 && divCnt < 2) cardPull = 1'b1;
    end
  end

  // cycle comparison and start-bit counting
  always @(negedge clk) begin
    if (compareOn && rstN) begin
      chk(lineLow == expLow(), "R1 lineLow", lineLow, expLow());
      chk(txReady == (mMode == 0), "R2 txReady", txReady, mMode == 0);
      chk(iterFlag == mFlag, "R7 iterFlag", iterFlag, mFlag);
    end
    if (lineLow && !prevLow && relRun >= 20) starts++;
    relRun = lineLow ? 0 : relRun + 1;
    prevLow = lineLow;
  end

  task automatic sendAndWait(input bit [7:0] b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = b; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    while (!txReady) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic runByte(input bit [7:0] b, input int mi, input int nf,
                         input int style, output int nStarts);
    int s0;
    @(negedge clk);
    maxIter = 3'(mi); nackFirst = nf; pullStyle = style;
    s0 = starts;
    sendAndWait(b);
    nStarts = starts - s0;
  endtask

  task automatic pulseClear();
    @(negedge clk); clrIter = 1'b1;
    @(negedge clk); clrIter = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int n;
    rstN = 1'b0; txValid = 1'b0; txData = 8'h00; maxIter = 3'd0;
    clrIter = 1'b0; cardPull = 1'b0; sampleTick = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(txReady == 1'b1, "R2 reset ready", txReady, 1);
    chk(lineLow == 1'b0, "R1 reset line released", lineLow, 0);
    chk(iterFlag == 1'b0, "R7 reset flag", iterFlag, 0);
    compareOn = 1;

    // R1: several data patterns, no NACK
    runByte(8'h00, 3, 0, 0, n);
    runByte(8'hFF, 3, 0, 0, n);
    runByte(8'hA5, 3, 0, 0, n);
    runByte(8'h5A, 3, 0, 0, n);
    chk(n == 1, "R1 single send when accepted", n, 1);

    // R4: zero allowance, NACK ignored for retry purposes
    runByte(8'h5A, 0, 8, 0, n);
    chk(n == 1, "R4 no repeat at maxIter 0", n, 1);
    chk(iterFlag == 1'b0, "R4 flag stays clear", iterFlag, 0);

    // R5 R6 R7 R10: every attempt rejected, two repeats allowed
    runByte(8'h5A, 2, 8, 0, n);
    chk(n == 3, "R5 R6 attempts with maxIter 2", n, 3);
    chk(iterFlag == 1'b1, "R7 flag at limit", iterFlag, 1);
    chk(txReady == 1'b1, "R10 ready after final NACK", txReady, 1);

    // R7: sticky across a clean byte
    runByte(8'h3C, 2, 0, 0, n);
    chk(iterFlag == 1'b1, "R7 flag sticky", iterFlag, 1);

    // R8: clear command
    pulseClear();
    chk(iterFlag == 1'b0, "R8 flag cleared", iterFlag, 0);

    // R6: maximum allowance, eight sends in total
    runByte(8'h5A, 7, 8, 0, n);
    chk(n == 8, "R6 eight sends at maxIter 7", n, 8);
    chk(iterFlag == 1'b1, "R6 flag after eight sends", iterFlag, 1);
    pulseClear();

    // R9: repeat accepted stops repetition, counter restarts per byte
    runByte(8'h5A, 3, 1, 0, n);
    chk(n == 2, "R9 stop after accepted repeat", n, 2);
    chk(iterFlag == 1'b0, "R9 no flag below limit", iterFlag, 0);
    runByte(8'h5A, 3, 3, 0, n);
    chk(n == 4, "R9 full allowance for next byte", n, 4);
    chk(iterFlag == 1'b1, "R9 flag on full use", iterFlag, 1);
    pulseClear();

    // R3: low pulse that ends before mid-guard is not a NACK
    runByte(8'h5A, 3, 8, 1, n);
    chk(n == 1, "R3 off-centre pulse ignored", n, 1);
    chk(iterFlag == 1'b0, "R3 flag unaffected", iterFlag, 0);

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule